// File: doc/BRIEF.md
# Key-Locked System Control Register Bank

This block is a bank of control words on a plain 32-bit register bus. A write is presented as address, write enable and write data and is taken on the rising clock edge. A read is presented as address and read enable, and the read data is driven in the same cycle. The bank holds three groups of configuration words that are set to fixed values at reset: clock-generator control, peripheral clock control and reset control. Every write to these groups is guarded by a lock. The lock is set at reset. Software clears it by writing a 16-bit unlock key to a dedicated address and sets it again by writing a 16-bit lock key to another address.

A few addresses bypass the lock. These are a one-bit scratch control word, the two key addresses and a read-only lock status word. When the bank is unlocked, setting bit 0 of the first reset-control word stores the value and also emits a one-cycle system reset request. Some addresses inside the mapped ranges are holes that ignore writes even when the bank is unlocked. Addresses that are not mapped, and addresses that are not word-aligned, read as zero and ignore writes.

Top module: `keyctl_bank`

## Requirements
- R1: After reset the bank is locked. Address 0x00C reads 1 and address 0x000 reads 0. The words at 0x100, 0x104 and 0x108 read 0x0001A008, 0x10C reads 0x0000003F, 0x120 reads 0x1F000400 and 0x240 reads 0x01F33F0F.
- R2: A write to 0x008 whose bits [15:0] equal 0xDF0D clears the lock on the next clock edge. Bits [31:16] are don't-care. A write to 0x008 with any other low half leaves the lock unchanged.
- R3: A write to 0x004 whose bits [15:0] equal 0x767B sets the lock on the next clock edge. A write to 0x004 with any other low half leaves the lock unchanged.
- R4: Address 0x00C reads the lock state in bit 0 (1 = locked) with zeros above it. Writes to 0x00C have no effect.
- R5: Reads of 0x004 and 0x008 return zero.
- R6: Address 0x000 holds one writable bit in bit 0 and reads zero in bits [31:1]. It accepts writes whether the bank is locked or not.
- R7: While the bank is locked, writes to the groups at 0x100–0x11C, 0x120–0x16C and 0x200–0x258 change nothing, and no reset request is raised.
- R8: While the bank is unlocked, a full 32-bit write to any non-hole word of the three groups is read back unchanged.
- R9: While the bank is unlocked, a write to 0x200 with bit 0 set stores the value and drives `sys_rst_req` high for exactly the one cycle that follows the write edge. A write to 0x200 with bit 0 clear raises no request.
- R10: Writes to 0x10C and 0x250 are ignored even when the bank is unlocked. Address 0x25C always reads 0x00000001, and writes to it have no effect.
- R11: Unmapped addresses (for example 0x300 and 0x1B0) read zero and ignore writes. An address with bits [1:0] not equal to zero is treated as unmapped.
- R12: `bus_rdata` is zero whenever `bus_re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the cycle `bus_re` is high |
| sys_rst_req | output | 1 | Registered one-cycle system reset request |

## Verification
The assertions check the following on every cycle. A correct key write moves the lock flop on the next edge, and any other cycle leaves the lock unchanged. A group's storage is stable in every cycle without a gated write to it. The reset request is never longer than one cycle and always follows a soft-reset write. The lock status word and the constant word read back correctly. Only the bench's scenarios can show the rest: the reset values of the words, the effect of wrong keys that differ by one bit, the write holes, the misaligned and unmapped addresses, and full-width readback after unlocking.

// File: rtl/keyctl_pkg.sv
package keyctl_pkg;
  localparam int AW    = 12;
  localparam int DW    = 32;
  localparam int IDX_W = 5;

  typedef enum logic [1:0] {GRP_PLL, GRP_CLK, GRP_RST} grp_e;

  // Reset value of word idx inside group g.
  function automatic logic [DW-1:0] grp_reset(grp_e g, int idx);
    logic [DW-1:0] v;
    v = '0;
    case (g)
      GRP_PLL: begin
        if (idx < 3) v = 32'h0001A008;
        else if (idx == 3) v = 32'h0000003F;
        else if (idx < 7) v = 32'h00014000;
      end
      GRP_CLK: begin
        case (idx)
          0:       v = 32'h1F000400;
          1:       v = 32'h18400003;
          2:       v = 32'h01E03201;
          3:       v = 32'h01FFCCCD;
          4, 5:    v = 32'h00101941;
          6, 7:    v = 32'h00000001;
          8, 9, 10: v = 32'h00003C01;
          11:      v = 32'h00002821;
          12:      v = 32'h00001E03;
          13, 14:  v = 32'h00003F03;
          15:      v = 32'h00501903;
          17:      v = 32'h00000F03;
          18:      v = 32'h00000F01;
          default: v = '0;
        endcase
      end
      GRP_RST: begin
        if (idx == 16) v = 32'h01F33F0F;
        else if (idx == 19) v = 32'h00000040;
      end
      default: v = '0;
    endcase
    return v;
  endfunction

  // Word-aligned address inside [base, base + 4*cnt).
  function automatic logic in_range(logic [AW-1:0] a, int base, int cnt);
    return (a[1:0] == 2'b00) && (int'(a) >= base) && (int'(a) < base + 4 * cnt);
  endfunction

  function automatic logic [IDX_W-1:0] word_idx(logic [AW-1:0] a, int base);
    logic [AW-1:0] d;
    d = a - AW'(base);
    return d[IDX_W+1:2];
  endfunction
endpackage

// File: rtl/keyctl_lock.sv
module keyctl_lock #(
  parameter int          KEY_W      = 16,
  parameter logic [15:0] LOCK_KEY   = 16'h767B,
  parameter logic [15:0] UNLOCK_KEY = 16'hDF0D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_wr,
  input  logic             unlock_wr,
  input  logic [KEY_W-1:0] key,
  output logic             locked
);
  logic lock_hit, unlock_hit;
  assign lock_hit   = lock_wr   && (key == KEY_W'(LOCK_KEY));
  assign unlock_hit = unlock_wr && (key == KEY_W'(UNLOCK_KEY));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          locked <= 1'b1;
    else if (lock_hit)   locked <= 1'b1;
    else if (unlock_hit) locked <= 1'b0;
  end

  a_r3_lock_sets: assert property (@(posedge clk) disable iff (!rst_n)
    lock_hit |=> locked);
  a_r2_unlock_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock_hit && !lock_hit) |=> !locked);
  a_r2_wrong_key_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(lock_hit || unlock_hit) |=> $stable(locked));
endmodule

// File: rtl/keyctl_group.sv
module keyctl_group
  import keyctl_pkg::*;
#(
  parameter grp_e        GRP       = GRP_PLL,
  parameter int          COUNT     = 8,
  parameter logic [31:0] HOLE_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data
);
  logic [COUNT-1:0][DW-1:0] mem_q;

  for (genvar i = 0; i < COUNT; i++) begin : g_word
    localparam logic [DW-1:0] RST_VAL = grp_reset(GRP, i);
    if (HOLE_MASK[i]) begin : g_hole
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q[i] <= RST_VAL;
      end
    end else begin : g_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q[i] <= RST_VAL;
        else if (wr_en && (int'(wr_idx) == i)) mem_q[i] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_idx) < COUNT) rd_data = mem_q[rd_idx];
  end

  a_r7_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem_q));
endmodule

// File: rtl/keyctl_pulse.sv
module keyctl_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= fire && !pulse;
  end

  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/keyctl_bank.sv
module keyctl_bank
  import keyctl_pkg::*;
#(
  parameter int          KEY_W      = 16,
  parameter logic [15:0] LOCK_KEY   = 16'h767B,
  parameter logic [15:0] UNLOCK_KEY = 16'hDF0D
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [11:0]   bus_addr,
  input  logic          bus_we,
  input  logic [31:0]   bus_wdata,
  input  logic          bus_re,
  output logic [31:0]   bus_rdata,
  output logic          sys_rst_req
);
  localparam logic [AW-1:0] A_CTL    = 12'h000;
  localparam logic [AW-1:0] A_LOCK   = 12'h004;
  localparam logic [AW-1:0] A_UNLOCK = 12'h008;
  localparam logic [AW-1:0] A_STATUS = 12'h00C;
  localparam logic [AW-1:0] A_SOFT   = 12'h200;
  localparam logic [AW-1:0] A_ONE    = 12'h25C;
  localparam int PLL_BASE = 'h100, PLL_CNT = 8;
  localparam int CLK_BASE = 'h120, CLK_CNT = 20;
  localparam int RST_BASE = 'h200, RST_CNT = 23;

  logic locked, ctl_q;
  logic pll_hit, clk_hit, rst_hit;
  logic cfg_we, soft_fire;
  logic [DW-1:0] pll_rd, clk_rd, rst_rd;

  assign pll_hit   = in_range(bus_addr, PLL_BASE, PLL_CNT);
  assign clk_hit   = in_range(bus_addr, CLK_BASE, CLK_CNT);
  assign rst_hit   = in_range(bus_addr, RST_BASE, RST_CNT);
  assign cfg_we    = bus_we && !locked;
  assign soft_fire = cfg_we && (bus_addr == A_SOFT) && bus_wdata[0];

  keyctl_lock #(.KEY_W(KEY_W), .LOCK_KEY(LOCK_KEY), .UNLOCK_KEY(UNLOCK_KEY)) i_lock (
    .clk(clk), .rst_n(rst_n),
    .lock_wr  (bus_we && bus_addr == A_LOCK),
    .unlock_wr(bus_we && bus_addr == A_UNLOCK),
    .key      (bus_wdata[KEY_W-1:0]),
    .locked   (locked)
  );

  keyctl_group #(.GRP(GRP_PLL), .COUNT(PLL_CNT), .HOLE_MASK(32'h0000_0008)) i_pll (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we && pll_hit),
    .wr_idx(word_idx(bus_addr, PLL_BASE)), .wr_data(bus_wdata),
    .rd_idx(word_idx(bus_addr, PLL_BASE)), .rd_data(pll_rd)
  );

  keyctl_group #(.GRP(GRP_CLK), .COUNT(CLK_CNT), .HOLE_MASK(32'h0)) i_clk (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we && clk_hit),
    .wr_idx(word_idx(bus_addr, CLK_BASE)), .wr_data(bus_wdata),
    .rd_idx(word_idx(bus_addr, CLK_BASE)), .rd_data(clk_rd)
  );

  keyctl_group #(.GRP(GRP_RST), .COUNT(RST_CNT), .HOLE_MASK(32'h0010_0000)) i_rst (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we && rst_hit),
    .wr_idx(word_idx(bus_addr, RST_BASE)), .wr_data(bus_wdata),
    .rd_idx(word_idx(bus_addr, RST_BASE)), .rd_data(rst_rd)
  );

  keyctl_pulse i_pulse (.clk(clk), .rst_n(rst_n), .fire(soft_fire), .pulse(sys_rst_req));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ctl_q <= 1'b0;
    else if (bus_we && bus_addr == A_CTL) ctl_q <= bus_wdata[0];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      if (bus_addr == A_CTL)         bus_rdata = {31'b0, ctl_q};
      else if (bus_addr == A_STATUS) bus_rdata = {31'b0, locked};
      else if (bus_addr == A_ONE)    bus_rdata = 32'h1;
      else if (pll_hit)              bus_rdata = pll_rd;
      else if (clk_hit)              bus_rdata = clk_rd;
      else if (rst_hit)              bus_rdata = rst_rd;
    end
  end

  a_r9_req_follows_soft_write: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(bus_we && bus_addr == A_SOFT && bus_wdata[0] && !locked));
  a_r4_status_reads_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == A_STATUS) |-> (bus_rdata == {31'b0, locked}));
  a_r10_const_word: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == A_ONE) |-> (bus_rdata == 32'h1));
  a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |-> (bus_rdata == '0));
endmodule

// File: tb/test_keyctl_bank.sv
module test_keyctl_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        sys_rst_req;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [31:0] exp;
    logic [11:0] addr;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  keyctl_bank i_keyctl_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .sys_rst_req(sys_rst_req)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  // Driver: pushes the expected read value into the scoreboard.
  task automatic rd(logic [11:0] a, logic [31:0] e, string tag);
    item_t it;
    it.exp = e; it.addr = a; it.tag = tag;
    @(posedge clk); #1;
    bus_addr = a; bus_re = 1'b1;
    sb_q.push_back(it);
    @(posedge clk); #1;
    bus_re = 1'b0;
  endtask

  // Monitor: compares away from the active edge.
  always @(negedge clk) begin
    if (rst_n && bus_re && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(it.tag, bus_rdata, it.exp);
    end
  end

  task automatic pulse_check(logic exp_first, string tag);
    @(negedge clk); check(tag, {31'b0, sys_rst_req}, {31'b0, exp_first});
    @(negedge clk); check(tag, {31'b0, sys_rst_req}, 32'h0);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    join_none

    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;

    @(negedge clk);
    check("R12 idle read data", bus_rdata, 32'h0);
    check("R1 no request after reset", {31'b0, sys_rst_req}, 32'h0);

    rd(12'h00C, 32'h1, "R1 locked at reset");
    rd(12'h000, 32'h0, "R1 ctl bit reset");
    rd(12'h100, 32'h0001A008, "R1 pll word 0");
    rd(12'h104, 32'h0001A008, "R1 pll word 1");
    rd(12'h108, 32'h0001A008, "R1 pll word 2");
    rd(12'h10C, 32'h0000003F, "R1 pll status");
    rd(12'h120, 32'h1F000400, "R1 clk word 0");
    rd(12'h240, 32'h01F33F0F, "R1 rst word 16");

    rd(12'h004, 32'h0, "R5 lock key reads zero");
    rd(12'h008, 32'h0, "R5 unlock key reads zero");

    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, 32'h1, "R6 ctl writable while locked");
    wr(12'h000, 32'h0000_0000);
    rd(12'h000, 32'h0, "R6 ctl cleared");

    wr(12'h100, 32'h1234_5678);
    rd(12'h100, 32'h0001A008, "R7 locked write discarded");
    wr(12'h200, 32'h0000_0001);
    pulse_check(1'b0, "R7 no request while locked");
    rd(12'h200, 32'h0, "R7 locked rst write discarded");

    wr(12'h008, 32'h0000_DF0C);
    rd(12'h00C, 32'h1, "R2 wrong unlock key");
    wr(12'h004, 32'h0000_DF0D);
    rd(12'h00C, 32'h1, "R2 unlock key at lock address");
    wr(12'h008, 32'hABCD_DF0D);
    rd(12'h00C, 32'h0, "R2 unlock with upper bits set");

    wr(12'h00C, 32'h0000_0001);
    rd(12'h00C, 32'h0, "R4 status write ignored");

    wr(12'h104, 32'hCAFE_F00D);
    rd(12'h104, 32'hCAFE_F00D, "R8 pll readback");
    wr(12'h16C, 32'h89AB_CDEF);
    rd(12'h16C, 32'h89AB_CDEF, "R8 clk readback");
    wr(12'h258, 32'h1357_9BDF);
    rd(12'h258, 32'h1357_9BDF, "R8 rst readback");

    wr(12'h10C, 32'h0000_0000);
    rd(12'h10C, 32'h0000003F, "R10 pll status hole");
    wr(12'h250, 32'hFFFF_FFFF);
    rd(12'h250, 32'h0, "R10 rst hole");
    wr(12'h25C, 32'h0000_0000);
    rd(12'h25C, 32'h1, "R10 constant word");

    wr(12'h300, 32'hFFFF_FFFF);
    rd(12'h300, 32'h0, "R11 unmapped");
    rd(12'h1B0, 32'h0, "R11 unmapped gap");
    wr(12'h102, 32'hFFFF_FFFF);
    rd(12'h100, 32'h0001A008, "R11 misaligned write ignored");
    rd(12'h102, 32'h0, "R11 misaligned read zero");

    wr(12'h200, 32'h0000_0005);
    pulse_check(1'b1, "R9 soft reset pulse");
    rd(12'h200, 32'h0000_0005, "R9 soft value stored");
    wr(12'h200, 32'h0000_0004);
    pulse_check(1'b0, "R9 bit0 clear no pulse");

    wr(12'h004, 32'h0000_767A);
    rd(12'h00C, 32'h0, "R3 wrong lock key");
    wr(12'h004, 32'hFFFF_767B);
    rd(12'h00C, 32'h1, "R3 lock key");
    wr(12'h120, 32'h0000_0001);
    rd(12'h120, 32'h1F000400, "R7 relocked write discarded");

    @(negedge clk);
    check("R12 idle read data end", bus_rdata, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule